// File: doc/BRIEF.md
# Burst Bus Target with Ready Handshake

This block is the responding side of a synchronous bus on which addresses and data share one set of lines. A transaction opens when the initiator raises `frame_i`. On that first edge the target captures the command and the address. If the address falls inside the target's window, the target claims the transaction. It then moves words between the bus and a small register file, one word on every rising edge where both ready signals are high. Bursts have no fixed length. The initiator marks the final word by lowering `frame_i` while that word is still pending.

On reads, the target leaves the shared lines undriven for one cycle after the address phase, so that ownership of the lines can change hands. It then drives the contents of the register file.

The target can end a burst by itself in three ways:
- It disconnects with data when the burst reaches the top of its window.
- It disconnects without data when its register file stays busy too long.
- It refuses a command it does not support inside its window (abort).

In every case it keeps `stop_o` high until the initiator has lowered `frame_i`.

Top module: `burst_target`

## Requirements
- R1: While reset is held, `trdy_o`, `stop_o`, `claim_o`, `ad_oe_o`, `rf_wr_o` and `rf_rd_o` are all low.
- R2: A transaction whose address lies outside [BASE, BASE + 4*WORDS) is ignored. The target never raises `claim_o`, `trdy_o`, `stop_o` or `rf_wr_o` before the bus returns to idle.
- R3: A word moves only on a rising edge where `irdy_i` and `trdy_o` are both high. On a write, `rf_wr_o` is high in that cycle and `rf_wdata_o` carries `ad_i`.
- R4: The first word uses register index (address − BASE)/4. Each later word of the same burst uses the next index, which is a 4-byte address step.
- R5: On a read (command code 4'h6), the cycle after the address phase has `ad_oe_o` and `trdy_o` low. From the next cycle on, `ad_o` carries the contents of the current register and `ad_oe_o` is high.
- R6: A word transferred while `frame_i` is low is the last word of the burst. In the next cycle `claim_o` and `trdy_o` are low.
- R7: Either side can insert wait states. A cycle with `irdy_i` low transfers nothing. While `rf_ready_i` is low, `trdy_o` stays low.
- R8: The word at register index WORDS−1 is accepted with `stop_o` and `trdy_o` both high. The index never wraps to 0 within a burst.
- R9: After MAX_WAIT consecutive data cycles with `rf_ready_i` low, the target raises `stop_o` with `trdy_o` low, and that cycle transfers no word.
- R10: A command inside the window that is neither read (4'h6) nor write (4'h7) is answered with `stop_o` high and `claim_o` low, and no register is written.
- R11: Once `stop_o` is raised while `frame_i` is high, it stays high with `trdy_o` low until `frame_i` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all signals sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Transaction active; low on the final word |
| cmd_i | input | 4 | Command, valid in the address phase |
| ad_i | input | ADW | Shared address/data lines as seen by the target |
| irdy_i | input | 1 | Initiator ready for the current word |
| ad_o | output | ADW | Read data driven onto the shared lines |
| ad_oe_o | output | 1 | Target drives the shared lines |
| trdy_o | output | 1 | Target ready for the current word |
| stop_o | output | 1 | Target requests the end of the transaction |
| claim_o | output | 1 | Target has accepted the transaction |
| rf_addr_o | output | log2(WORDS) | Register index of the current word |
| rf_wr_o | output | 1 | Register write strobe |
| rf_wdata_o | output | ADW | Register write data |
| rf_rd_o | output | 1 | Register read strobe (word delivered) |
| rf_rdata_i | input | ADW | Register read data for `rf_addr_o` |
| rf_ready_i | input | 1 | Register file can complete a word this cycle |

## Verification
A wrong burst index shows within one edge. The word lands in the wrong register, or wrong read data appears on `ad_o` in the same cycle as the faulty index. A state machine that misreads the address phase shows at once. It either claims a foreign transaction or drives the shared lines during the turnaround cycle. A faulty wait counter or stop logic shows within MAX_WAIT + 1 cycles, as a missing disconnect or as an early release of `stop_o` before `frame_i` falls. The bench drives each of these paths and checks the ports and the register contents cycle by cycle.

// File: rtl/burst_target.sv
module burst_target #(
  parameter int             ADW      = 32,
  parameter int             WORDS    = 16,
  parameter logic [ADW-1:0] BASE     = 'h1000,
  parameter int             MAX_WAIT = 4,
  parameter logic [3:0]     CMD_RD   = 4'h6,
  parameter logic [3:0]     CMD_WR   = 4'h7
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_i,
  input  logic [3:0]               cmd_i,
  input  logic [ADW-1:0]           ad_i,
  input  logic                     irdy_i,
  output logic [ADW-1:0]           ad_o,
  output logic                     ad_oe_o,
  output logic                     trdy_o,
  output logic                     stop_o,
  output logic                     claim_o,
  output logic [$clog2(WORDS)-1:0] rf_addr_o,
  output logic                     rf_wr_o,
  output logic [ADW-1:0]           rf_wdata_o,
  output logic                     rf_rd_o,
  input  logic [ADW-1:0]           rf_rdata_i,
  input  logic                     rf_ready_i
);
  localparam int IW = $clog2(WORDS);
  localparam int LB = IW + 2;
  localparam int CW = $clog2(MAX_WAIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_DATA, S_STOP, S_ABORT, S_SKIP} st_t;

  st_t           st;
  logic          is_rd;
  logic [IW-1:0] idx;
  logic [CW-1:0] wcnt;

  wire hit     = ad_i[ADW-1:LB] == BASE[ADW-1:LB];
  wire known   = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  wire at_end  = idx == IW'(WORDS - 1);
  wire timeout = wcnt == CW'(MAX_WAIT);
  wire xfer    = trdy_o && irdy_i;

  assign trdy_o     = (st == S_DATA) && rf_ready_i && !timeout;
  assign stop_o     = ((st == S_DATA) && (timeout || (at_end && trdy_o))) ||
                      (st == S_STOP) || (st == S_ABORT);
  assign claim_o    = (st == S_TURN) || (st == S_DATA) || (st == S_STOP);
  assign ad_oe_o    = (st == S_DATA) && is_rd;
  assign ad_o       = rf_rdata_i;
  assign rf_addr_o  = idx;
  assign rf_wr_o    = xfer && !is_rd;
  assign rf_rd_o    = xfer && is_rd;
  assign rf_wdata_o = ad_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      is_rd <= 1'b0;
      idx   <= '0;
      wcnt  <= '0;
    end else begin
      wcnt <= ((st == S_DATA) && !rf_ready_i && !timeout) ? wcnt + 1'b1 : '0;
      case (st)
        S_IDLE:
          if (frame_i) begin
            if (!hit)        st <= S_SKIP;
            else if (!known) st <= S_ABORT;
            else begin
              is_rd <= cmd_i == CMD_RD;
              idx   <= ad_i[LB-1:2];
              st    <= (cmd_i == CMD_RD) ? S_TURN : S_DATA;
            end
          end
        S_TURN: st <= S_DATA;
        S_DATA:
          if (xfer) begin
            if (!frame_i)    st <= S_IDLE;
            else if (at_end) st <= S_STOP;
            else             idx <= idx + 1'b1;
          end else if (timeout) begin
            st <= frame_i ? S_STOP : S_IDLE;
          end
        S_STOP, S_ABORT: if (!frame_i) st <= S_IDLE;
        S_SKIP: if (!frame_i && !irdy_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ready_needs_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_o |-> claim_o);

  p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rf_wr_o || rf_rd_o) && frame_i && !stop_o) |=>
      (rf_addr_o == $past(rf_addr_o) + IW'(1)));

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe_o) |-> $past(claim_o) && !$past(ad_oe_o));

  p_last_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rf_wr_o || rf_rd_o) && !frame_i) |=> (!claim_o && !trdy_o));

  p_window_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rf_wr_o || rf_rd_o) && frame_i && (rf_addr_o == IW'(WORDS - 1))) |=>
      (stop_o && !trdy_o));

  p_abort_no_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !claim_o) |-> (!trdy_o && !rf_wr_o));

  p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !trdy_o && frame_i) |=> (stop_o && !trdy_o));
endmodule

// File: tb/tb_burst_target.sv
module tb_burst_target;
  localparam int          ADW   = 32;
  localparam int          WORDS = 16;
  localparam logic [31:0] BASE  = 32'h1000;
  localparam int          MW    = 4;
  localparam logic [3:0]  RD    = 4'h6;
  localparam logic [3:0]  WR    = 4'h7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 1'b0, irdy = 1'b0, rf_ready = 1'b1;
  logic [3:0] cmd = '0;
  logic [ADW-1:0] ad = '0;
  logic [ADW-1:0] ad_o, rf_wdata, rf_rdata;
  logic ad_oe, trdy, stop, claim, rf_wr, rf_rd;
  logic [3:0] rf_addr;

  logic [31:0] mem [WORDS];
  logic [31:0] expm [WORDS];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  burst_target #(.ADW(ADW), .WORDS(WORDS), .BASE(BASE), .MAX_WAIT(MW),
                 .CMD_RD(RD), .CMD_WR(WR)) dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame), .cmd_i(cmd), .ad_i(ad),
    .irdy_i(irdy), .ad_o(ad_o), .ad_oe_o(ad_oe), .trdy_o(trdy),
    .stop_o(stop), .claim_o(claim), .rf_addr_o(rf_addr), .rf_wr_o(rf_wr),
    .rf_wdata_o(rf_wdata), .rf_rd_o(rf_rd), .rf_rdata_i(rf_rdata),
    .rf_ready_i(rf_ready));

  assign rf_rdata = mem[rf_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 32'hA000_0000 + i;
    end else if (rf_wr) begin
      mem[rf_addr] <= rf_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [3:0] c, input logic [31:0] a);
    @(negedge clk); frame = 1'b1; cmd = c; ad = a; irdy = 1'b0;
  endtask

  task automatic idle_bus;
    @(negedge clk); frame = 1'b0; irdy = 1'b0; cmd = '0; ad = '0; rf_ready = 1'b1;
  endtask

  task automatic mem_matches(input string req);
    logic ok = 1'b1;
    for (int i = 0; i < WORDS; i++) if (mem[i] !== expm[i]) ok = 1'b0;
    check(req, {31'd0, ok}, 32'd1);
  endtask

  task automatic t_reset;
    #1;
    check("R1 trdy", {31'd0, trdy}, 0);
    check("R1 stop", {31'd0, stop}, 0);
    check("R1 claim", {31'd0, claim}, 0);
    check("R1 oe", {31'd0, ad_oe}, 0);
    check("R1 strobes", {30'd0, rf_wr, rf_rd}, 0);
  endtask

  task automatic t_write(input int s, input int n, input bit gap);
    addr_phase(WR, BASE + 32'(4 * s));
    for (int i = 0; i < n; i++) begin
      if (gap && i == 1) begin
        @(negedge clk); frame = 1'b1; irdy = 1'b0; ad = 32'hDEAD_0000;
        #1 check("R7 initiator wait", {31'd0, rf_wr}, 0);
      end
      @(negedge clk); frame = (i != n - 1); irdy = 1'b1; ad = 32'h5000_0000 + 32'(s * 16 + i);
      #1;
      check("R3 trdy", {31'd0, trdy}, 1);
      check("R3 write strobe", {31'd0, rf_wr}, 1);
      check("R4 index", {28'd0, rf_addr}, 32'(s + i));
      expm[s + i] = 32'h5000_0000 + 32'(s * 16 + i);
    end
    idle_bus; #1;
    check("R6 release", {30'd0, claim, trdy}, 0);
    mem_matches("R4 contents");
  endtask

  task automatic t_read(input int s, input int n, input bit twait);
    addr_phase(RD, BASE + 32'(4 * s));
    @(negedge clk); frame = 1'b1; irdy = 1'b1; ad = '0;
    #1;
    check("R5 turnaround oe", {31'd0, ad_oe}, 0);
    check("R5 turnaround trdy", {31'd0, trdy}, 0);
    for (int i = 0; i < n; i++) begin
      if (twait && i == 1) begin
        @(negedge clk); frame = 1'b1; irdy = 1'b1; rf_ready = 1'b0;
        #1 check("R7 target wait", {30'd0, trdy, rf_rd}, 0);
      end
      @(negedge clk); frame = (i != n - 1); irdy = 1'b1; rf_ready = 1'b1;
      #1;
      check("R5 oe", {31'd0, ad_oe}, 1);
      check("R5 data", ad_o, expm[s + i]);
      check("R3 read strobe", {30'd0, trdy, rf_rd}, 3);
    end
    idle_bus; #1;
    check("R6 release read", {29'd0, claim, trdy, ad_oe}, 0);
  endtask

  task automatic t_miss;
    addr_phase(WR, BASE + 32'(4 * WORDS));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); frame = (i != 2); irdy = 1'b1; ad = 32'hBAD0_0000 + 32'(i);
      #1 check("R2 ignored", {28'd0, claim, trdy, stop, rf_wr}, 0);
    end
    idle_bus; #1 check("R2 quiet", {29'd0, claim, trdy, stop}, 0);
    mem_matches("R2 no write");
  endtask

  task automatic t_window_end;
    addr_phase(WR, BASE + 32'(4 * (WORDS - 2)));
    @(negedge clk); frame = 1'b1; irdy = 1'b1; ad = 32'h7700_0001;
    #1 check("R8 no early stop", {30'd0, stop, trdy}, 1);
    expm[WORDS - 2] = 32'h7700_0001;
    @(negedge clk); ad = 32'h7700_0002;
    #1 check("R8 stop with data", {30'd0, stop, trdy}, 3);
    expm[WORDS - 1] = 32'h7700_0002;
    @(negedge clk); ad = 32'h7700_0003;
    #1 check("R11 stop held", {29'd0, stop, trdy, rf_wr}, 4);
    @(negedge clk); frame = 1'b0;
    #1 check("R11 stop until frame low", {30'd0, stop, trdy}, 2);
    idle_bus; #1 check("R11 released", {30'd0, stop, claim}, 0);
    mem_matches("R8 no wrap");
  endtask

  task automatic t_timeout;
    addr_phase(WR, BASE + 32'd12);
    for (int k = 0; k < MW; k++) begin
      @(negedge clk); frame = 1'b1; irdy = 1'b1; rf_ready = 1'b0; ad = 32'h6600_0000;
      #1 check("R9 waiting", {30'd0, stop, trdy}, 0);
    end
    @(negedge clk);
    #1 check("R9 disconnect no data", {29'd0, stop, trdy, rf_wr}, 4);
    @(negedge clk); frame = 1'b0; rf_ready = 1'b1;
    #1 check("R11 timeout stop held", {29'd0, stop, trdy, rf_wr}, 4);
    idle_bus; #1 check("R9 released", {30'd0, stop, claim}, 0);
    mem_matches("R9 no write");
  endtask

  task automatic t_abort;
    addr_phase(4'h3, BASE + 32'd8);
    @(negedge clk); frame = 1'b1; irdy = 1'b1; ad = 32'h4400_0000;
    #1 check("R10 abort", {29'd0, stop, claim, trdy}, 4);
    @(negedge clk); frame = 1'b0;
    #1 check("R10 abort held", {30'd0, stop, rf_wr}, 2);
    idle_bus; #1 check("R10 released", {31'd0, stop}, 0);
    mem_matches("R10 no write");
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) expm[i] = 32'hA000_0000 + i;
    @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_write(2, 4, 1'b0);
    t_write(8, 3, 1'b1);
    t_write(5, 1, 1'b0);
    t_read(2, 4, 1'b0);
    t_read(8, 3, 1'b1);
    t_read(0, 1, 1'b0);
    t_miss;
    t_window_end;
    t_timeout;
    t_abort;
    t_read(WORDS - 2, 2, 1'b0);
    idle_bus;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule